// File: doc/BRIEF.md
# Keyboard Ghosting Filter

This block sits behind a key-matrix scanner and receives one snapshot per scan: up to eight slots, each holding a key code and a valid flag. A key code puts the column index in its low bits and the row index in the bits above them. The block drops the slots that are not valid and packs the remaining keys to the front, keeping their slot order. When function-key mode is on, it also removes every entry equal to the configured function-key code.

When three or more keys remain, the block compares every pair of them, one pair per clock. If any pair shares a row and any pair (the same pair or another) shares a column, the snapshot may hold phantom keys. In that case the whole snapshot is discarded and only a one-cycle drop pulse reports it. Otherwise the packed list is offered downstream with its key count. If a function key was removed, every forwarded code is raised by the number of matrix positions (rows times columns), so that the consumer selects its alternate key map.

Both data interfaces use valid/ready. A snapshot is taken in the cycle where `in_valid` and `in_ready` are both high. `in_ready` then stays low until that snapshot has been delivered or dropped. The output holds `out_valid` and all of its data unchanged until `out_ready` is seen high. The three configuration pins are sampled only when a snapshot is accepted.

Top module: `gf_ghost_filter`

## Requirements
- R1: After reset `out_valid` and `out_drop` are low and `in_ready` is high.
- R2: Only slots whose `in_vld` bit is set are counted and forwarded. They are packed into output slots 0 up to `out_count`-1, in rising input-slot order, and `out_count` equals their number.
- R3: A key code is `{row, col}`, with the column in the low log2(COLS) bits and the row in the log2(ROWS) bits above them. Rows and columns are compared on these fields only.
- R4: A snapshot with fewer than three remaining keys is never dropped.
- R5: With the filter enabled and three or more remaining keys, the snapshot is dropped if some pair of keys has equal rows and some pair has equal columns. A drop is a single-cycle `out_drop` pulse, and `out_valid` does not rise for that snapshot.
- R6: With `cfg_filter_en` low, every snapshot is forwarded, whatever its row and column pattern.
- R7: With `cfg_fn_en` high, each valid entry equal to `cfg_fn_code` is removed from the list and the count, and `out_fn` is set. The ghost check sees only the keys that remain.
- R8: When `out_fn` is set, each forwarded code equals its input code plus ROWS*COLS, on an output field one bit wider than the input code.
- R9: With `cfg_fn_en` low, an entry equal to `cfg_fn_code` is handled as an ordinary key and `out_fn` stays low.
- R10: `in_ready` is low from the cycle after acceptance until the result is handed off or dropped.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_keys`, `out_count` and `out_fn` hold.
- R12: Output slots at or above `out_count` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_filter_en | input | 1 | Enables the ghost check |
| cfg_fn_en | input | 1 | Enables function-key removal |
| cfg_fn_code | input | KW | Function-key code |
| in_valid | input | 1 | Snapshot offered |
| in_ready | output | 1 | Block idle and able to take a snapshot |
| in_keys | input | SLOTS*KW | Key codes, slot s at bits [s*KW +: KW] |
| in_vld | input | SLOTS | Per-slot valid flags |
| out_valid | output | 1 | Filtered snapshot available |
| out_ready | input | 1 | Downstream accepts the result |
| out_keys | output | SLOTS*(KW+1) | Packed, possibly offset codes |
| out_count | output | CNTW | Number of forwarded keys |
| out_fn | output | 1 | A function key was removed |
| out_drop | output | 1 | One-cycle pulse: snapshot discarded |

## Verification
The bench builds the block with its defaults: 16 rows, 8 columns and 8 slots, which gives 7-bit codes and an offset of 128. These values make it possible to send a full eight-key snapshot, whose scan takes 28 pair cycles. They also allow a row-15 key whose offset code reaches 254, and a case where the equal-row pair and the equal-column pair are disjoint. The bench also throttles `out_ready`, so the results of back-to-back snapshots must hold under back-pressure.

// File: rtl/gf_pkg.sv
package gf_pkg;
  typedef enum logic [1:0] {
    GF_IDLE = 2'd0,
    GF_SCAN = 2'd1,
    GF_OUT  = 2'd2
  } gf_state_e;
endpackage

// File: rtl/gf_compact.sv
// Packs the valid slots to the front and strips function-key entries.
module gf_compact #(
  parameter int SLOTS = 8,
  parameter int KW    = 7,
  parameter int CNTW  = 4
) (
  input  logic [SLOTS*KW-1:0] raw_keys,
  input  logic [SLOTS-1:0]    raw_vld,
  input  logic                fn_en,
  input  logic [KW-1:0]       fn_code,
  output logic [SLOTS*KW-1:0] packed_keys,
  output logic [CNTW-1:0]     packed_cnt,
  output logic                fn_hit
);
  always_comb begin
    int k;
    k           = 0;
    packed_keys = '0;
    fn_hit      = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (raw_vld[s]) begin
        if (fn_en && (raw_keys[s*KW +: KW] == fn_code)) begin
          fn_hit = 1'b1;
        end else begin
          packed_keys[k*KW +: KW] = raw_keys[s*KW +: KW];
          k = k + 1;
        end
      end
    end
    packed_cnt = CNTW'(k);
  end
endmodule

// File: rtl/gf_pair_scan.sv
// Walks all pairs (i<j) one per cycle, accumulating row and column matches.
module gf_pair_scan #(
  parameter int SLOTS = 8,
  parameter int KW    = 7,
  parameter int CW    = 3,
  parameter int CNTW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNTW-1:0]     count,
  input  logic [SLOTS*KW-1:0] keys,
  output logic                done,
  output logic                ghost
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic          busy, row_f, col_f;
  logic [IW-1:0] pi, pj;
  logic [KW-1:0] ka, kb;
  logic          row_m, col_m, last_j, last_pair;

  always_comb begin
    ka        = keys[pi*KW +: KW];
    kb        = keys[pj*KW +: KW];
    col_m     = (ka[CW-1:0] == kb[CW-1:0]);
    row_m     = (ka[KW-1:CW] == kb[KW-1:CW]);
    last_j    = (int'(pj) == int'(count) - 1);
    last_pair = last_j && (int'(pi) == int'(count) - 2);
    done      = busy && last_pair;
    ghost     = (row_f | row_m) & (col_f | col_m);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      row_f <= 1'b0;
      col_f <= 1'b0;
      pi    <= '0;
      pj    <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      row_f <= 1'b0;
      col_f <= 1'b0;
      pi    <= '0;
      pj    <= IW'(1);
    end else if (busy) begin
      row_f <= row_f | row_m;
      col_f <= col_f | col_m;
      if (last_pair) begin
        busy <= 1'b0;
      end else if (last_j) begin
        pi <= pi + 1'b1;
        pj <= pi + IW'(2);
      end else begin
        pj <= pj + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gf_ghost_filter.sv
module gf_ghost_filter #(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int SLOTS = 8,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int KW    = RW + CW,
  localparam int OKW   = KW + 1,
  localparam int CNTW  = $clog2(SLOTS + 1),
  localparam int TOTAL = ROWS * COLS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_filter_en,
  input  logic                 cfg_fn_en,
  input  logic [KW-1:0]        cfg_fn_code,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SLOTS*KW-1:0]  in_keys,
  input  logic [SLOTS-1:0]     in_vld,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SLOTS*OKW-1:0] out_keys,
  output logic [CNTW-1:0]      out_count,
  output logic                 out_fn,
  output logic                 out_drop
);
  import gf_pkg::*;

  gf_state_e            state;
  logic [SLOTS*KW-1:0]  hold_keys, c_keys;
  logic [CNTW-1:0]      hold_cnt, c_cnt;
  logic                 hold_fn, c_fn;
  logic                 accept, need_scan, scan_done, scan_ghost;

  gf_compact #(.SLOTS(SLOTS), .KW(KW), .CNTW(CNTW)) compact_i (
    .raw_keys   (in_keys),
    .raw_vld    (in_vld),
    .fn_en      (cfg_fn_en),
    .fn_code    (cfg_fn_code),
    .packed_keys(c_keys),
    .packed_cnt (c_cnt),
    .fn_hit     (c_fn)
  );

  assign in_ready  = (state == GF_IDLE);
  assign accept    = in_valid && in_ready;
  assign need_scan = cfg_filter_en && (c_cnt >= CNTW'(3));

  gf_pair_scan #(.SLOTS(SLOTS), .KW(KW), .CW(CW), .CNTW(CNTW)) scan_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept && need_scan),
    .count(hold_cnt),
    .keys (hold_keys),
    .done (scan_done),
    .ghost(scan_ghost)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= GF_IDLE;
      hold_keys <= '0;
      hold_cnt  <= '0;
      hold_fn   <= 1'b0;
      out_drop  <= 1'b0;
    end else begin
      out_drop <= 1'b0;
      unique case (state)
        GF_IDLE: if (accept) begin
          hold_keys <= c_keys;
          hold_cnt  <= c_cnt;
          hold_fn   <= c_fn;
          state     <= need_scan ? GF_SCAN : GF_OUT;
        end
        GF_SCAN: if (scan_done) begin
          if (scan_ghost) begin
            out_drop <= 1'b1;
            state    <= GF_IDLE;
          end else begin
            state <= GF_OUT;
          end
        end
        GF_OUT: if (out_ready) state <= GF_IDLE;
        default: state <= GF_IDLE;
      endcase
    end
  end

  assign out_valid = (state == GF_OUT);
  assign out_count = hold_cnt;
  assign out_fn    = hold_fn;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [OKW-1:0] base;
    assign base = {1'b0, hold_keys[s*KW +: KW]};
    assign out_keys[s*OKW +: OKW] =
      (CNTW'(s) >= hold_cnt) ? '0 : (hold_fn ? base + OKW'(TOTAL) : base);
  end
endmodule

// File: rtl/gf_checker.sv
module gf_checker #(
  parameter int SLOTS = 8,
  parameter int OKW   = 8,
  parameter int CNTW  = 4,
  parameter int TOTAL = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [SLOTS-1:0]     in_vld,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [SLOTS*OKW-1:0] out_keys,
  input logic [CNTW-1:0]      out_count,
  input logic                 out_fn,
  input logic                 out_drop
);
  logic [CNTW-1:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_cnt <= '0;
    else if (in_valid && in_ready) acc_cnt <= CNTW'($countones(in_vld));
  end

  AST_READY_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_keys) && $stable(out_count) && $stable(out_fn))); // R11
  AST_DROP_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_drop |-> !out_valid); // R5
  AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_drop |=> !out_drop); // R5
  AST_FEW_NEVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    out_drop |-> (acc_cnt >= CNTW'(3))); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count <= acc_cnt)); // R2
  AST_FN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fn && (out_count != '0)) |-> (out_keys[OKW-1:0] >= OKW'(TOTAL))); // R8
endmodule

bind gf_ghost_filter gf_checker #(
  .SLOTS(SLOTS), .OKW(OKW), .CNTW(CNTW), .TOTAL(TOTAL)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_vld   (in_vld),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_keys (out_keys),
  .out_count(out_count),
  .out_fn   (out_fn),
  .out_drop (out_drop)
);

// File: tb/gf_ghost_filter_tb.sv
module gf_ghost_filter_tb_top;
  localparam int SLOTS = 8;
  localparam int KW    = 7;
  localparam int OKW   = 8;
  localparam int CNTW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_filter_en = 1'b1, cfg_fn_en = 1'b0;
  logic [KW-1:0] cfg_fn_code = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SLOTS*KW-1:0] in_keys = '0;
  logic [SLOTS-1:0] in_vld = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [SLOTS*OKW-1:0] out_keys;
  logic [CNTW-1:0] out_count;
  logic out_fn, out_drop;

  always #2 clk = ~clk;

  gf_ghost_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_filter_en(cfg_filter_en), .cfg_fn_en(cfg_fn_en),
    .cfg_fn_code(cfg_fn_code), .in_valid(in_valid), .in_ready(in_ready),
    .in_keys(in_keys), .in_vld(in_vld), .out_valid(out_valid), .out_ready(out_ready),
    .out_keys(out_keys), .out_count(out_count), .out_fn(out_fn), .out_drop(out_drop)
  );

  typedef struct packed {
    logic                 drop;
    logic [CNTW-1:0]      cnt;
    logic                 fn;
    logic [SLOTS*OKW-1:0] keys;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [KW-1:0]    sk[SLOTS];
  logic [SLOTS-1:0] sv;

  function automatic logic [KW-1:0] mk(int r, int c);
    return {r[3:0], c[2:0]};
  endfunction

  task automatic clr();
    for (int s = 0; s < SLOTS; s++) sk[s] = KW'(7'h55 ^ s);
    sv = '0;
  endtask

  // Driver: model the expected outcome from the requirements, then offer the snapshot.
  task automatic send(string tag);
    exp_t e;
    logic [KW-1:0] lst[SLOTS];
    int n;
    bit rf, cf;
    n = 0;
    e = '0;
    for (int s = 0; s < SLOTS; s++) begin
      lst[s] = '0;
      if (sv[s]) begin
        if (cfg_fn_en && sk[s] == cfg_fn_code) e.fn = 1'b1;
        else begin lst[n] = sk[s]; n++; end
      end
    end
    rf = 1'b0; cf = 1'b0;
    if (cfg_filter_en && n >= 3)
      for (int i = 0; i < n; i++)
        for (int j = i + 1; j < n; j++) begin
          if (lst[i][2:0] == lst[j][2:0]) cf = 1'b1;
          if (lst[i][6:3] == lst[j][6:3]) rf = 1'b1;
        end
    e.drop = rf && cf;
    e.cnt  = CNTW'(n);
    for (int s = 0; s < n; s++)
      e.keys[s*OKW +: OKW] = {1'b0, lst[s]} + (e.fn ? OKW'(128) : OKW'(0));
    if (e.drop) begin e.cnt = '0; e.fn = 1'b0; e.keys = '0; end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int s = 0; s < SLOTS; s++) in_keys[s*KW +: KW] = sk[s];
    in_vld   = sv;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R10 in_ready after accept act=%b exp=0", in_ready);
    end
  endtask

  // Monitor: pop and compare each result.
  always @(negedge clk) begin
    if (rst_n && (out_drop || (out_valid && out_ready))) begin
      exp_t e; string t; exp_t a;
      a.drop = out_drop;
      a.cnt  = out_drop ? '0 : out_count;
      a.fn   = out_drop ? 1'b0 : out_fn;
      a.keys = out_drop ? '0 : out_keys;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected result drop=%b cnt=%0d", a.drop, a.cnt);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (a !== e) begin
          fails++;
          $display("FAIL %s act drop=%b cnt=%0d fn=%b keys=%h exp drop=%b cnt=%0d fn=%b keys=%h",
                   t, a.drop, a.cnt, a.fn, a.keys, e.drop, e.cnt, e.fn, e.keys);
        end
      end
    end
  end

  // Downstream back-pressure pattern.
  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk);
      #1;
      c++;
      out_ready = (c % 3) != 0;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (!(out_valid === 1'b0 && out_drop === 1'b0 && in_ready === 1'b1)) begin
      fails++;
      $display("FAIL R1 reset act=%b%b%b exp=001", out_valid, out_drop, in_ready);
    end
    rst_n = 1'b1;

    clr(); sk[0] = mk(1,1); sk[1] = mk(1,1); sv = 8'b11;
    send("R4 two keys sharing row and column");
    clr(); sk[0] = mk(2,3); sk[1] = mk(2,5); sk[2] = mk(6,3); sv = 8'b111;
    send("R5 three-key corner dropped");
    clr(); sk[0] = mk(1,0); sk[1] = mk(2,1); sk[2] = mk(3,2); sv = 8'b111;
    send("R5 three independent keys pass");
    clr(); sk[0] = mk(4,4); sk[2] = mk(5,5); sk[5] = mk(6,6); sk[7] = mk(7,7); sv = 8'b1010_0101;
    send("R2 R12 scattered valid slots packed");
    clr(); sk[0] = mk(0,0); sk[1] = mk(0,1); sk[2] = mk(4,6); sk[3] = mk(5,6); sv = 8'h0f;
    send("R3 R5 disjoint row pair and column pair dropped");
    cfg_filter_en = 1'b0;
    clr(); sk[0] = mk(2,3); sk[1] = mk(2,5); sk[2] = mk(6,3); sv = 8'b111;
    send("R6 filter off forwards corner");
    cfg_filter_en = 1'b1; cfg_fn_en = 1'b1; cfg_fn_code = mk(15,7);
    clr(); sk[0] = mk(15,7); sk[1] = mk(1,2); sk[2] = mk(15,6); sv = 8'b111;
    send("R7 R8 function key removed and offset to 254");
    clr(); sk[0] = mk(15,0); sk[1] = mk(15,7); sk[2] = mk(3,7); sv = 8'b111;
    send("R7 function key removal leaves two keys");
    clr(); sk[0] = mk(2,3); sk[1] = mk(15,7); sk[2] = mk(2,5); sk[3] = mk(6,3); sv = 8'hf;
    send("R7 ghost among remaining keys dropped");
    clr(); sk[0] = mk(15,7); sk[1] = mk(9,1); sk[2] = mk(15,7); sv = 8'b111;
    send("R7 repeated function key both removed");
    cfg_fn_en = 1'b0;
    clr(); sk[0] = mk(15,7); sk[1] = mk(1,2); sv = 8'b11;
    send("R9 function code as ordinary key");
    clr(); for (int s = 0; s < SLOTS; s++) sk[s] = mk(s, s); sv = 8'hff;
    send("R2 R5 eight independent keys pass");
    clr(); for (int s = 0; s < 6; s++) sk[s] = mk(s, s);
    sk[6] = mk(10,6); sk[7] = mk(10,0); sv = 8'hff;
    send("R5 eight keys ghost in final pairs");
    clr(); sv = 8'h00;
    send("R2 R4 empty snapshot");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 pending results act=%0d exp=0", exp_q.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule